// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Arbiter

This block sits between a set of interrupt sources and a processor with one interrupt input. It holds N identical slices, each with one event line and its own 8-bit vector. A rising edge on a slice's event line leaves a request pending in that slice. The pending requests of all slices are combined into one shared interrupt output.

When the processor pulls its active-low acknowledge low, the acknowledge enters slice 0 and moves down the chain. The first slice that holds a pending request takes the acknowledge and places its vector on the data output. A slice with nothing pending hands the acknowledge on to the next slice. The last slice always takes an acknowledge that reaches it. So priority depends only on position in the chain.

When the acknowledge is released, only the slice that took it drops its request. Every other pending request stays, and the interrupt output stays high for them.

Top module: `irq_chain_arbiter`

## Requirements
- R1: While reset is held, and after it, until an event edge arrives, `int_o` is 0, `grant_o` is all zeros and `data_o` is 8'h00.
- R2: A slice's request becomes pending at the first clock edge that samples its event line high after a cycle in which it was low. A line that is held high does not set the request again.
- R3: `int_o` is 1 exactly when at least one slice holds a pending request.
- R4: While `ack_n_i` is 0, the pending slice with the lowest index is the only bit set in `grant_o`, and `data_o` equals that slice's vector in the same cycle. Slice i's vector is `vec_i[i*8 +: 8]`.
- R5: While `ack_n_i` is 0 and no request is pending, the highest-index slice is granted and `data_o` equals its vector.
- R6: While `ack_n_i` is 1, `grant_o` is all zeros and `data_o` is 8'h00.
- R7: At the first clock edge that samples `ack_n_i` high after it was sampled low, only the slice granted in the last low cycle drops its request. The other requests stay pending. A new event edge in that same cycle keeps the slice pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_DEV | Event line of each slice; a rising edge raises a request |
| vec_i | input | N_DEV*8 | Vector of each slice, slice i at bits i*8 +: 8 |
| ack_n_i | input | 1 | Active-low interrupt acknowledge from the processor |
| int_o | output | 1 | Combined interrupt request |
| grant_o | output | N_DEV | One-hot mark of the slice that took the acknowledge |
| data_o | output | 8 | Vector returned during acknowledge, else zero |

## Verification
The bench drives several requests so that they are pending together, then acknowledges. A chain with priority in the wrong direction, or one that lets two slices drive the bus at once, returns the wrong or merged vector. Acknowledges with no request pending exercise the forced last slice; a design without that rule returns zero. Releases of the acknowledge check that a clear that spreads beyond the granted slice drops `int_o` too early. They also check that a clear which never fires grants the same slice again. Event lines held high across a clear catch a design that detects the level instead of the edge, because such a design raises the request again.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  parameter int unsigned VEC_W = 8;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic pend_o
);
  logic evt_q, evt_d;
  logic pend_q, pend_d;

  always_comb begin
    evt_d  = evt_i;
    pend_d = (evt_i & ~evt_q) | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      evt_q  <= evt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_ack_cell.sv
module irq_ack_cell #(
  parameter bit IS_LAST = 1'b0
) (
  input  logic ack_in_i,
  input  logic pend_i,
  output logic take_o,
  output logic ack_out_o
);
  logic want;

  generate
    if (IS_LAST) begin : g_tail
      assign want = 1'b1;
    end else begin : g_body
      assign want = pend_i;
    end
  endgenerate

  assign take_o    = ack_in_i & want;
  assign ack_out_o = ack_in_i & ~want;
endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge #(
  parameter int unsigned N_DEV = 4,
  parameter int unsigned VEC_W = irq_chain_pkg::VEC_W
) (
  input  logic [N_DEV-1:0]       take_i,
  input  logic [N_DEV*VEC_W-1:0] vec_i,
  output logic [VEC_W-1:0]       data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (take_i[i]) data_o = data_o | vec_i[i*VEC_W +: VEC_W];
    end
  end
endmodule

// File: rtl/irq_chain_arbiter.sv
module irq_chain_arbiter #(
  parameter int unsigned N_DEV = 4,
  parameter int unsigned VEC_W = irq_chain_pkg::VEC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_DEV-1:0]       evt_i,
  input  logic [N_DEV*VEC_W-1:0] vec_i,
  input  logic                   ack_n_i,
  output logic                   int_o,
  output logic [N_DEV-1:0]       grant_o,
  output logic [VEC_W-1:0]       data_o
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             ack_act;
  logic             ack_act_q, ack_act_d;
  logic [N_DEV-1:0] grant_q, grant_d;
  logic             grant_en;
  logic             release_ev;
  logic [N_DEV-1:0] clr;
  logic [N_DEV-1:0] pend_q;
  logic [N_DEV:0]   ack_path;
  logic [N_DEV-1:0] take;

  assign ack_act     = ~ack_n_i;
  assign ack_path[0] = ack_act;
  assign release_ev  = ack_act_q & ~ack_act;
  assign clr         = grant_q & {N_DEV{release_ev}};

  genvar g;
  generate
    for (g = 0; g < N_DEV; g++) begin : g_slice
      irq_req_latch u_req (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .evt_i  (evt_i[g]),
        .clr_i  (clr[g]),
        .pend_o (pend_q[g])
      );
      irq_ack_cell #(.IS_LAST(g == N_DEV-1)) u_cell (
        .ack_in_i  (ack_path[g]),
        .pend_i    (pend_q[g]),
        .take_o    (take[g]),
        .ack_out_o (ack_path[g+1])
      );
    end
  endgenerate

  irq_vec_merge #(.N_DEV(N_DEV), .VEC_W(VEC_W)) u_merge (
    .take_i (take),
    .vec_i  (vec_i),
    .data_o (data_o)
  );

  // remember who held the acknowledge, for the clear at release
  assign grant_en = ack_act;
  always_comb begin
    ack_act_d = ack_act;
    grant_d   = grant_en ? take : grant_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ack_act_q <= 1'b0;
      grant_q   <= '0;
    end else begin
      ack_act_q <= ack_act_d;
      grant_q   <= grant_d;
    end
  end

  assign int_o   = |pend_q;
  assign grant_o = take;
endmodule

// File: rtl/irq_chain_checker.sv
module irq_chain_checker #(
  parameter int unsigned N_DEV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_n_i,
  input logic [N_DEV-1:0] evt_i,
  input logic             int_o,
  input logic [N_DEV-1:0] grant_o,
  input logic [N_DEV-1:0] pend_q
);
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ack_n_i |-> (grant_o == '0));

  a_r4_single_taker: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_i |-> ($countones(grant_o) == 1));

  a_r5_tail_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n_i && pend_q == '0) |-> grant_o[N_DEV-1]);

  a_r3_int_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    int_o == (pend_q != '0));

  a_r2_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_o) |-> $past(evt_i != '0));

  a_r7_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ack_n_i) && ack_n_i) |=>
      (((~$past(grant_o, 2)) & $past(pend_q) & ~pend_q) == '0));
endmodule

bind irq_chain_arbiter irq_chain_checker #(.N_DEV(N_DEV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ack_n_i (ack_n_i),
  .evt_i   (evt_i),
  .int_o   (int_o),
  .grant_o (grant_o),
  .pend_q  (pend_q)
);

// File: tb/tb_irq_chain_arbiter.sv
module tb_irq_chain_arbiter;
  localparam int N = 4;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   evt;
  logic [N*W-1:0] vec;
  logic           ack_n;
  logic           int_o;
  logic [N-1:0]   grant;
  logic [W-1:0]   data;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  // model state
  logic [N-1:0] m_pend, m_evtq, m_gq;
  logic         m_ackq;

  always #2 clk = ~clk;

  irq_chain_arbiter #(.N_DEV(N), .VEC_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .vec_i(vec),
    .ack_n_i(ack_n), .int_o(int_o), .grant_o(grant), .data_o(data)
  );

  function automatic logic [N-1:0] exp_take(logic [N-1:0] p, logic an);
    logic [N-1:0] r = '0;
    if (!an) begin
      r[N-1] = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (p[i]) begin r = '0; r[i] = 1'b1; break; end
      end
    end
    return r;
  endfunction

  function automatic logic [W-1:0] exp_data(logic [N-1:0] t);
    logic [W-1:0] d = '0;
    for (int i = 0; i < N; i++) if (t[i]) d = vec[i*W +: W];
    return d;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance one clock edge, updating the model; inputs change at negedge
  task automatic tick();
    logic [N-1:0] rise, clr;
    rise = evt & ~m_evtq;
    clr  = (m_ackq && ack_n) ? m_gq : '0;
    m_gq   = !ack_n ? exp_take(m_pend, ack_n) : m_gq;
    m_pend = rise | (m_pend & ~clr);
    m_evtq = evt;
    m_ackq = !ack_n;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_outputs();
    logic [N-1:0] t;
    string tg;
    t = exp_take(m_pend, ack_n);
    chk("R2/R3/R7 int_o", int_o, (m_pend != '0));
    if (ack_n)              tg = "R6";
    else if (m_pend == '0)  tg = "R5";
    else                    tg = "R4";
    chk({tg, " grant_o"}, grant, t);
    chk({tg, " data_o"}, data, exp_data(t));
  endtask

  task automatic step(logic [N-1:0] e, logic an);
    evt = e; ack_n = an;
    #0.5;
    check_outputs();
    tick();
    check_outputs();
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) vec[i*W +: W] = W'(8'h3C + 8'h25 * i);
    evt = '0; ack_n = 1'b1; rst_n = 1'b0;
    m_pend = '0; m_evtq = '0; m_gq = '0; m_ackq = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 int_o in reset", int_o, 0);
    chk("R1 data_o in reset", data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 int_o after reset", int_o, 0);
    chk("R1 grant_o after reset", grant, 0);

    // R5: acknowledge with nothing pending goes to the tail
    step('0, 1'b0);
    step('0, 1'b1);

    // R4/R7: slices 0 and 2 pending, slice 0 wins, slice 2 survives
    step(4'b0101, 1'b1);
    step(4'b0101, 1'b1);
    step(4'b0101, 1'b0);
    step(4'b0101, 1'b0);
    step(4'b0101, 1'b1);
    chk("R7 slice 2 still pending", int_o, 1);
    // R2: held-high line does not re-arm slice 0; next ack is slice 2
    step(4'b0101, 1'b0);
    chk("R4 second ack vector", data, vec[2*W +: W]);
    step(4'b0101, 1'b1);
    chk("R2 no re-arm from held level", int_o, 0);

    // R7: new edge in the release cycle keeps the slice pending
    step(4'b0000, 1'b1);
    step(4'b0010, 1'b1);
    step(4'b0000, 1'b0);
    step(4'b0010, 1'b1);
    chk("R7 edge at release keeps request", int_o, 1);

    // constrained random
    for (int c = 0; c < 600; c++) begin
      logic [N-1:0] e;
      logic an;
      e = evt;
      for (int i = 0; i < N; i++) if ($urandom_range(0, 3) == 0) e[i] = ~e[i];
      an = ($urandom_range(0, 4) != 0) ? 1'b1 : 1'b0;
      if (!ack_n && $urandom_range(0, 1) == 0) an = 1'b0;
      step(e, an);
    end
    step('0, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule